// File: doc/BRIEF.md
# Capability Access Checker

This block sits in front of a load, store or instruction-fetch path and decides whether one memory access, made through a capability, may go ahead. Each request carries the capability's validity tag, its sealed flag, a three-bit permission field, uncompressed 64-bit base and top bounds, and the pointer address. It also carries the access kind and the access size in bytes. One cycle after the request the block answers with either a grant or a fault. A fault comes with a three-bit cause code.

The answer is produced by a small state machine with three states. `ST_IDLE` means no response is being presented. `ST_GRANT` presents a granted response. `ST_FAULT` presents a refused response together with its cause.

The transitions are:
- Any state goes to `ST_GRANT` on a request that passes every test.
- Any state goes to `ST_FAULT` on a request that fails any test.
- Any state goes to `ST_IDLE` in a cycle with no request.

Requests may arrive back to back, one per cycle.

Top module: `cap_access_check`

## Requirements
- R1: A request whose validity tag is clear is refused with cause 1 (tag), whatever its other fields hold.
- R2: A request is granted only if base <= addr and addr + size <= top. Top is exclusive, and the sum is formed one bit wider than the address, so a range that wraps past the end of the address space is refused. An out-of-range request is refused with cause 4 (bounds).
- R3: Permission bit 0 allows load (kind 0), bit 1 allows store (kind 1) and bit 2 allows fetch (kind 2). A request whose kind bit is clear is refused with cause 3 (permission). Kind 3 is reserved and is always refused with cause 3.
- R4: A tagged, sealed capability is refused with cause 2 (seal), even when its permissions, size and bounds would allow the access.
- R5: When several faults apply, the cause reported is the first of: tag, seal, permission, length, bounds.
- R6: rsp_valid is high in exactly the cycle after each cycle in which req_valid is high, so back-to-back requests get back-to-back responses.
- R7: Sizes 1, 2, 4, 8 and 16 are legal. Any other nonzero size is refused with cause 5 (length).
- R8: A size of zero is refused with cause 5 (length).
- R9: After reset, and in every cycle with no response, rsp_valid, rsp_grant and rsp_cause are all zero.
- R10: A granted response carries cause 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_tag | input | 1 | Capability validity tag |
| req_sealed | input | 1 | Capability is sealed |
| req_perms | input | 3 | Permission bits: 0 load, 1 store, 2 fetch |
| req_addr | input | 64 | Pointer address of the first byte |
| req_base | input | 64 | Lowest accessible address (inclusive) |
| req_top | input | 64 | End of the accessible range (exclusive) |
| req_kind | input | 2 | Access kind: 0 load, 1 store, 2 fetch, 3 reserved |
| req_size | input | 5 | Access size in bytes |
| rsp_valid | output | 1 | Response present |
| rsp_grant | output | 1 | Access allowed |
| rsp_cause | output | 3 | 0 none, 1 tag, 2 seal, 3 permission, 4 bounds, 5 length |

## Verification
The bench places accesses exactly at the top bound and one byte past it. A checker that treated top as inclusive, or that compared the wrong end of the range, would grant the second of these or refuse the first. A range near the top of the address space that wraps around zero must be refused; a checker with a 64-bit sum would wrap and grant it. Requests that break several rules at once expose a wrong priority order. Requests with sizes 0, 3 and 17, the reserved kind, and a sealed but otherwise perfect capability catch a checker that grants through a gap in its decoding. A burst of back-to-back requests followed by an idle cycle catches a response that sticks or lags.

// File: rtl/cap_chk_pkg.sv
package cap_chk_pkg;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_e;

    typedef enum logic [2:0] {
        CAUSE_NONE   = 3'd0,
        CAUSE_TAG    = 3'd1,
        CAUSE_SEAL   = 3'd2,
        CAUSE_PERM   = 3'd3,
        CAUSE_BOUNDS = 3'd4,
        CAUSE_LEN    = 3'd5
    } fault_cause_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_GRANT = 2'd1,
        ST_FAULT = 2'd2
    } chk_state_e;

    localparam int PERM_W         = 3;
    localparam int PERM_LOAD_IDX  = 0;
    localparam int PERM_STORE_IDX = 1;
    localparam int PERM_FETCH_IDX = 2;

endpackage

// File: rtl/cap_perm_gate.sv
module cap_perm_gate
    import cap_chk_pkg::*;
(
    input  logic              tag,
    input  logic              sealed,
    input  logic [PERM_W-1:0] perms,
    input  logic [1:0]        kind,
    output logic              tag_bad,
    output logic              seal_bad,
    output logic              perm_bad
);

    acc_kind_e kind_e;

    assign kind_e   = acc_kind_e'(kind);
    assign tag_bad  = ~tag;
    assign seal_bad = sealed;

    always_comb begin
        unique case (kind_e)
            ACC_LOAD:  perm_bad = ~perms[PERM_LOAD_IDX];
            ACC_STORE: perm_bad = ~perms[PERM_STORE_IDX];
            ACC_FETCH: perm_bad = ~perms[PERM_FETCH_IDX];
            default:   perm_bad = 1'b1;
        endcase
    end

endmodule

// File: rtl/cap_range_gate.sv
module cap_range_gate #(
    parameter int ADDR_W   = 64,
    parameter int SIZE_W   = 5,
    parameter int MAX_LOG2 = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] top,
    input  logic [SIZE_W-1:0] size,
    output logic              len_bad,
    output logic              range_bad
);

    localparam int NUM_SIZES = MAX_LOG2 + 1;
    localparam int SUM_W     = ADDR_W + 1;
    localparam int PAD_W     = SUM_W - SIZE_W;

    logic [NUM_SIZES-1:0] size_hit;
    logic [SUM_W-1:0]     end_sum;

    for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
        assign size_hit[g] = (size == SIZE_W'(1 << g));
    end

    assign len_bad   = ~|size_hit;
    assign end_sum   = {1'b0, addr} + {{PAD_W{1'b0}}, size};
    assign range_bad = (addr < base) || (end_sum > {1'b0, top});

endmodule

// File: rtl/cap_fault_rank.sv
module cap_fault_rank
    import cap_chk_pkg::*;
(
    input  logic         tag_bad,
    input  logic         seal_bad,
    input  logic         perm_bad,
    input  logic         len_bad,
    input  logic         range_bad,
    output fault_cause_e cause
);

    always_comb begin
        if (tag_bad)        cause = CAUSE_TAG;
        else if (seal_bad)  cause = CAUSE_SEAL;
        else if (perm_bad)  cause = CAUSE_PERM;
        else if (len_bad)   cause = CAUSE_LEN;
        else if (range_bad) cause = CAUSE_BOUNDS;
        else                cause = CAUSE_NONE;
    end

endmodule

// File: rtl/cap_access_check.sv
module cap_access_check
    import cap_chk_pkg::*;
#(
    parameter int ADDR_W   = 64,
    parameter int SIZE_W   = 5,
    parameter int MAX_LOG2 = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_tag,
    input  logic              req_sealed,
    input  logic [2:0]        req_perms,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [ADDR_W-1:0] req_base,
    input  logic [ADDR_W-1:0] req_top,
    input  logic [1:0]        req_kind,
    input  logic [SIZE_W-1:0] req_size,
    output logic              rsp_valid,
    output logic              rsp_grant,
    output logic [2:0]        rsp_cause
);

    logic         tag_bad, seal_bad, perm_bad, len_bad, range_bad;
    fault_cause_e cause_now;
    fault_cause_e cause_q;
    chk_state_e   state_q, state_d;

    cap_perm_gate u_perm (
        .tag      (req_tag),
        .sealed   (req_sealed),
        .perms    (req_perms),
        .kind     (req_kind),
        .tag_bad  (tag_bad),
        .seal_bad (seal_bad),
        .perm_bad (perm_bad)
    );

    cap_range_gate #(
        .ADDR_W   (ADDR_W),
        .SIZE_W   (SIZE_W),
        .MAX_LOG2 (MAX_LOG2)
    ) u_range (
        .addr      (req_addr),
        .base      (req_base),
        .top       (req_top),
        .size      (req_size),
        .len_bad   (len_bad),
        .range_bad (range_bad)
    );

    cap_fault_rank u_rank (
        .tag_bad   (tag_bad),
        .seal_bad  (seal_bad),
        .perm_bad  (perm_bad),
        .len_bad   (len_bad),
        .range_bad (range_bad),
        .cause     (cause_now)
    );

    // next-state selection
    always_comb begin
        if (!req_valid)                 state_d = ST_IDLE;
        else if (cause_now == CAUSE_NONE) state_d = ST_GRANT;
        else                            state_d = ST_FAULT;
    end

    // state and cause registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cause_q <= CAUSE_NONE;
        end else begin
            state_q <= state_d;
            cause_q <= req_valid ? cause_now : CAUSE_NONE;
        end
    end

    // outputs decoded from state
    always_comb begin
        unique case (state_q)
            ST_IDLE: begin
                rsp_valid = 1'b0;
                rsp_grant = 1'b0;
            end
            ST_GRANT: begin
                rsp_valid = 1'b1;
                rsp_grant = 1'b1;
            end
            ST_FAULT: begin
                rsp_valid = 1'b1;
                rsp_grant = 1'b0;
            end
            default: begin
                rsp_valid = 1'b0;
                rsp_grant = 1'b0;
            end
        endcase
    end

    assign rsp_cause = cause_q;

    AST_TAG_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_tag) |=> (rsp_valid && !rsp_grant && rsp_cause == CAUSE_TAG)); // R1
    AST_BELOW_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr < req_base) |=> !rsp_grant); // R2
    AST_SEALED_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_tag && req_sealed) |=> (!rsp_grant && rsp_cause == CAUSE_SEAL)); // R4
    AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R6
    AST_NO_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && !rsp_grant && rsp_cause == CAUSE_NONE)); // R9
    AST_ZERO_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_size == '0) |=> !rsp_grant); // R8
    AST_GRANT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_grant |-> (rsp_valid && rsp_cause == CAUSE_NONE)); // R10

endmodule

// File: tb/cap_access_check_bench.sv
`timescale 1ns/1ps
module cap_access_check_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_tag = 1'b0;
    logic        req_sealed = 1'b0;
    logic [2:0]  req_perms = '0;
    logic [63:0] req_addr = '0;
    logic [63:0] req_base = '0;
    logic [63:0] req_top = '0;
    logic [1:0]  req_kind = '0;
    logic [4:0]  req_size = '0;
    logic        rsp_valid, rsp_grant;
    logic [2:0]  rsp_cause;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    cap_access_check u_cap_access_check (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_tag(req_tag),
        .req_sealed(req_sealed), .req_perms(req_perms), .req_addr(req_addr),
        .req_base(req_base), .req_top(req_top), .req_kind(req_kind),
        .req_size(req_size), .rsp_valid(rsp_valid), .rsp_grant(rsp_grant),
        .rsp_cause(rsp_cause)
    );

    task automatic check_rsp(input string rq, input logic ev, input logic eg, input logic [2:0] ec);
        checks++;
        if (rsp_valid !== ev || rsp_grant !== eg || rsp_cause !== ec) begin
            fails++;
            $display("FAIL %s: valid/grant/cause = %b/%b/%0d, expected %b/%b/%0d",
                     rq, rsp_valid, rsp_grant, rsp_cause, ev, eg, ec);
        end
    endtask

    task automatic drive(input logic t, input logic s, input logic [2:0] p, input logic [1:0] k,
                         input logic [63:0] a, input logic [63:0] b, input logic [63:0] tp,
                         input logic [4:0] sz);
        req_valid = 1'b1; req_tag = t; req_sealed = s; req_perms = p; req_kind = k;
        req_addr = a; req_base = b; req_top = tp; req_size = sz;
    endtask

    // one request, answer checked at the next falling edge
    task automatic one(input string rq, input logic t, input logic s, input logic [2:0] p,
                       input logic [1:0] k, input logic [63:0] a, input logic [63:0] b,
                       input logic [63:0] tp, input logic [4:0] sz,
                       input logic eg, input logic [2:0] ec);
        @(negedge clk);
        drive(t, s, p, k, a, b, tp, sz);
        @(negedge clk);
        req_valid = 1'b0;
        check_rsp(rq, 1'b1, eg, ec);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check_rsp("R9 reset", 1'b0, 1'b0, 3'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check_rsp("R9 idle after reset", 1'b0, 1'b0, 3'd0);
    endtask

    task automatic t_bounds;
        one("R2 load in range", 1, 0, 3'b001, 2'd0, 64'h1000, 64'h1000, 64'h2000, 5'd8, 1, 3'd0);
        one("R2 store ends at top", 1, 0, 3'b010, 2'd1, 64'h1FF0, 64'h1000, 64'h2000, 5'd16, 1, 3'd0);
        one("R2 one byte past top", 1, 0, 3'b010, 2'd1, 64'h1FF1, 64'h1000, 64'h2000, 5'd16, 0, 3'd4);
        one("R2 below base", 1, 0, 3'b001, 2'd0, 64'h0FFF, 64'h1000, 64'h2000, 5'd1, 0, 3'd4);
        one("R2 wraparound", 1, 0, 3'b001, 2'd0, 64'hFFFF_FFFF_FFFF_FFF8, 64'h0,
            64'hFFFF_FFFF_FFFF_FFFF, 5'd16, 0, 3'd4);
    endtask

    task automatic t_perms;
        one("R3 fetch with load only", 1, 0, 3'b001, 2'd2, 64'h1000, 64'h1000, 64'h2000, 5'd4, 0, 3'd3);
        one("R3 fetch allowed", 1, 0, 3'b100, 2'd2, 64'h1000, 64'h1000, 64'h2000, 5'd4, 1, 3'd0);
        one("R3 store without bit", 1, 0, 3'b101, 2'd1, 64'h1000, 64'h1000, 64'h2000, 5'd4, 0, 3'd3);
        one("R3 reserved kind", 1, 0, 3'b111, 2'd3, 64'h1000, 64'h1000, 64'h2000, 5'd4, 0, 3'd3);
    endtask

    task automatic t_tag_seal;
        one("R1 untagged all else bad", 0, 1, 3'b000, 2'd3, 64'h0, 64'h1000, 64'h2000, 5'd0, 0, 3'd1);
        one("R1 untagged all else good", 0, 0, 3'b111, 2'd0, 64'h1000, 64'h1000, 64'h2000, 5'd8, 0, 3'd1);
        one("R4 sealed otherwise good", 1, 1, 3'b111, 2'd0, 64'h1000, 64'h1000, 64'h2000, 5'd8, 0, 3'd2);
    endtask

    task automatic t_priority;
        one("R5 seal over perm", 1, 1, 3'b000, 2'd0, 64'h1000, 64'h1000, 64'h2000, 5'd8, 0, 3'd2);
        one("R5 perm over length", 1, 0, 3'b000, 2'd0, 64'h1000, 64'h1000, 64'h2000, 5'd3, 0, 3'd3);
        one("R5 length over bounds", 1, 0, 3'b001, 2'd0, 64'h0, 64'h1000, 64'h2000, 5'd3, 0, 3'd5);
    endtask

    task automatic t_sizes;
        for (int i = 0; i < 5; i++)
            one("R7 legal size", 1, 0, 3'b001, 2'd0, 64'h1000, 64'h1000, 64'h2000,
                5'(1 << i), 1, 3'd0);
        one("R7 size 3", 1, 0, 3'b001, 2'd0, 64'h1000, 64'h1000, 64'h2000, 5'd3, 0, 3'd5);
        one("R7 size 17", 1, 0, 3'b001, 2'd0, 64'h1000, 64'h1000, 64'h2000, 5'd17, 0, 3'd5);
        one("R8 size zero", 1, 0, 3'b001, 2'd0, 64'h1000, 64'h1000, 64'h2000, 5'd0, 0, 3'd5);
    endtask

    task automatic t_back_to_back;
        @(negedge clk);
        drive(1, 0, 3'b001, 2'd0, 64'h0, 64'h1000, 64'h2000, 5'd4);
        @(negedge clk);
        check_rsp("R6 first of burst", 1'b1, 1'b0, 3'd4);
        drive(1, 0, 3'b001, 2'd0, 64'h1800, 64'h1000, 64'h2000, 5'd4);
        @(negedge clk);
        check_rsp("R10 second of burst", 1'b1, 1'b1, 3'd0);
        drive(1, 1, 3'b001, 2'd0, 64'h1800, 64'h1000, 64'h2000, 5'd4);
        @(negedge clk);
        req_valid = 1'b0;
        check_rsp("R6 third of burst", 1'b1, 1'b0, 3'd2);
        @(negedge clk);
        check_rsp("R9 idle after burst", 1'b0, 1'b0, 3'd0);
    endtask

    initial begin
        t_reset();
        t_bounds();
        t_perms();
        t_tag_seal();
        t_priority();
        t_sizes();
        t_back_to_back();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule